// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block resolves where an interrupt request should go. A request carries an 8-bit destination value, a one-bit addressing mode (physical or logical), a 2-bit shorthand code, the index of the agent that sends it and a flag asking for single-target delivery. The block compares the request against configuration held for each of `N_AGENTS` receiving agents and produces a registered bitmask with one bit per agent. The configuration for each agent is a physical ID, a logical destination byte and a 4-bit destination model.

In physical mode the destination is compared with the physical IDs. In logical mode each agent applies its own model, either flat or cluster. A nonzero shorthand replaces the destination lookup with one of three fixed patterns that depend on the sender. When single-target delivery is requested, a second registered output names the lowest-numbered agent in the mask, both as a one-hot vector and as an index.

A small state machine tracks result emission. It has two states: `ST_IDLE` (no result pending) and `ST_EMIT` (a result is on the outputs this cycle). It has four transitions: *accept* (`ST_IDLE`→`ST_EMIT` on a request), *stream* (`ST_EMIT`→`ST_EMIT` on a back-to-back request), *drain* (`ST_EMIT`→`ST_IDLE` with no request) and *wait* (`ST_IDLE`→`ST_IDLE`).

Top module: `irqdm_top`

## Requirements
- R1: After reset `out_valid` is 0, `out_mask` is 0, and every agent k has physical ID k, logical destination 0x00 and destination model 0xF.
- R2: With `req_logical`=0 and `req_short`=0, destination 0xFF selects every agent.
- R3: With `req_logical`=0, `req_short`=0 and a destination other than 0xFF, exactly the agents whose physical ID equals the destination are selected. This may be none, one or several agents.
- R4: With `req_logical`=1 and `req_short`=0, an agent with model 0xF is selected when the destination AND its logical byte is nonzero.
- R5: With `req_logical`=1 and `req_short`=0, an agent with model 0x0 is selected when destination bits [7:4] equal its logical bits [7:4] and destination bits [3:0] AND its logical bits [3:0] is nonzero.
- R6: In logical mode, an agent whose model is neither 0x0 nor 0xF is never selected.
- R7: Shorthand 1 selects only agent `req_sender`, and the destination and mode are ignored.
- R8: Shorthand 2 selects every agent, including the sender.
- R9: Shorthand 3 selects every agent except `req_sender`.
- R10: When `req_lowpri`=1, `out_target` is the lowest set bit of the resulting mask, `out_target_idx` is its index and `out_target_hit` is 1. For an empty mask all three are 0. When `req_lowpri`=0, all three are 0.
- R11: A request accepted at a clock edge appears on the outputs after that same edge, with `out_valid` high for exactly that cycle. Back-to-back requests give back-to-back results.
- R12: A write with `cfg_we`=1 updates agent `cfg_agent`. The field is chosen by `cfg_field`: 0 writes the physical ID from `cfg_data`, 1 writes the logical byte from `cfg_data`, and 2 writes the model from `cfg_data[3:0]`. Code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_agent | input | IDXW | Agent being configured |
| cfg_field | input | 2 | Field select: 0 physical ID, 1 logical byte, 2 model |
| cfg_data | input | 8 | Write data |
| req_valid | input | 1 | Request strobe |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_short | input | 2 | Shorthand: 0 destination, 1 self, 2 all, 3 all but self |
| req_dest | input | 8 | Destination value |
| req_sender | input | IDXW | Index of sending agent |
| req_lowpri | input | 1 | Request a single lowest-indexed target |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | N_AGENTS | Selected agents |
| out_target | output | N_AGENTS | One-hot single target |
| out_target_idx | output | IDXW | Index of single target |
| out_target_hit | output | 1 | Single target exists |

## Verification
All results are registered behind the request. The mask, the single target and the valid pulse for a request strobed before edge k are due right after edge k and are gone one edge later unless another request follows. The bench drives each request at a falling edge and drops it at the next falling edge. It samples the outputs at that second falling edge, which is half a period after the one register stage. It then samples once more to see the valid pulse end. Configuration writes are placed in cycles without requests, so each result reflects settled configuration.

// File: rtl/irqdm_pkg.sv
package irqdm_pkg;

    typedef enum logic [1:0] {
        CFG_PHYS  = 2'd0,
        CFG_LOGIC = 2'd1,
        CFG_MODEL = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] PHYS_BCAST    = 8'hFF;

endpackage

// File: rtl/irqdm_cfg_regs.sv
module irqdm_cfg_regs
    import irqdm_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDXW = $clog2(N_AGENTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDXW-1:0]         agent,
    input  logic [1:0]              field,
    input  logic [7:0]              data,
    output logic [N_AGENTS*8-1:0]   phys_flat,
    output logic [N_AGENTS*8-1:0]   logic_flat,
    output logic [N_AGENTS*4-1:0]   model_flat
);

    cfg_field_e fsel;
    assign fsel = cfg_field_e'(field);

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        localparam logic [7:0] RST_ID = 8'(g);
        logic sel;
        assign sel = we && (agent == IDXW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                phys_flat[g*8 +: 8]  <= RST_ID;
                logic_flat[g*8 +: 8] <= 8'h00;
                model_flat[g*4 +: 4] <= MODEL_FLAT;
            end else if (sel) begin
                case (fsel)
                    CFG_PHYS:  phys_flat[g*8 +: 8]  <= data;
                    CFG_LOGIC: logic_flat[g*8 +: 8] <= data;
                    CFG_MODEL: model_flat[g*4 +: 4] <= data[3:0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqdm_match.sv
module irqdm_match
    import irqdm_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDXW = $clog2(N_AGENTS)
) (
    input  logic [7:0]              dest,
    input  logic                    logical,
    input  logic [1:0]              short_code,
    input  logic [IDXW-1:0]         sender,
    input  logic [N_AGENTS*8-1:0]   phys_flat,
    input  logic [N_AGENTS*8-1:0]   logic_flat,
    input  logic [N_AGENTS*4-1:0]   model_flat,
    output logic [N_AGENTS-1:0]     mask
);

    logic [N_AGENTS-1:0] dest_mask;
    logic [N_AGENTS-1:0] self_mask;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_cmp
        logic [7:0] pid;
        logic [7:0] ldst;
        logic [3:0] mdl;
        logic       phys_hit;
        logic       flat_hit;
        logic       clus_hit;

        assign pid  = phys_flat[g*8 +: 8];
        assign ldst = logic_flat[g*8 +: 8];
        assign mdl  = model_flat[g*4 +: 4];

        assign phys_hit = (dest == PHYS_BCAST) || (pid == dest);
        assign flat_hit = (mdl == MODEL_FLAT) && (|(dest & ldst));
        assign clus_hit = (mdl == MODEL_CLUSTER)
                       && (dest[7:4] == ldst[7:4])
                       && (|(dest[3:0] & ldst[3:0]));

        assign dest_mask[g] = logical ? (flat_hit || clus_hit) : phys_hit;
        assign self_mask[g] = (sender == IDXW'(g));
    end

    always_comb begin
        unique case (shorthand_e'(short_code))
            SH_DEST:   mask = dest_mask;
            SH_SELF:   mask = self_mask;
            SH_ALL:    mask = '1;
            SH_OTHERS: mask = ~self_mask;
            default:   mask = '0;
        endcase
    end

endmodule

// File: rtl/irqdm_lowest_pick.sv
module irqdm_lowest_pick #(
    parameter int N_AGENTS = 8,
    localparam int IDXW = $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] mask,
    output logic [N_AGENTS-1:0] onehot,
    output logic [IDXW-1:0]     idx,
    output logic                found
);

    assign onehot = mask & (~mask + N_AGENTS'(1));
    assign found  = |mask;

    always_comb begin
        idx = '0;
        for (int k = N_AGENTS - 1; k >= 0; k--) begin
            if (mask[k]) idx = IDXW'(k);
        end
    end

endmodule

// File: rtl/irqdm_top.sv
module irqdm_top
    import irqdm_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDXW = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDXW-1:0]     cfg_agent,
    input  logic [1:0]          cfg_field,
    input  logic [7:0]          cfg_data,
    input  logic                req_valid,
    input  logic                req_logical,
    input  logic [1:0]          req_short,
    input  logic [7:0]          req_dest,
    input  logic [IDXW-1:0]     req_sender,
    input  logic                req_lowpri,
    output logic                out_valid,
    output logic [N_AGENTS-1:0] out_mask,
    output logic [N_AGENTS-1:0] out_target,
    output logic [IDXW-1:0]     out_target_idx,
    output logic                out_target_hit
);

    logic [N_AGENTS*8-1:0] phys_flat;
    logic [N_AGENTS*8-1:0] logic_flat;
    logic [N_AGENTS*4-1:0] model_flat;
    logic [N_AGENTS-1:0]   mask_c;
    logic [N_AGENTS-1:0]   pick_c;
    logic [IDXW-1:0]       pick_idx_c;
    logic                  pick_found_c;

    irqdm_cfg_regs #(.N_AGENTS(N_AGENTS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .agent      (cfg_agent),
        .field      (cfg_field),
        .data       (cfg_data),
        .phys_flat  (phys_flat),
        .logic_flat (logic_flat),
        .model_flat (model_flat)
    );

    irqdm_match #(.N_AGENTS(N_AGENTS)) u_match (
        .dest       (req_dest),
        .logical    (req_logical),
        .short_code (req_short),
        .sender     (req_sender),
        .phys_flat  (phys_flat),
        .logic_flat (logic_flat),
        .model_flat (model_flat),
        .mask       (mask_c)
    );

    irqdm_lowest_pick #(.N_AGENTS(N_AGENTS)) u_pick (
        .mask   (mask_c),
        .onehot (pick_c),
        .idx    (pick_idx_c),
        .found  (pick_found_c)
    );

    // Emission state machine
    state_e st_q;
    state_e st_d;

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_EMIT : ST_IDLE;  // accept / wait
            ST_EMIT: st_d = req_valid ? ST_EMIT : ST_IDLE;  // stream / drain
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign out_valid = (st_q == ST_EMIT);

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_mask       <= '0;
            out_target     <= '0;
            out_target_idx <= '0;
            out_target_hit <= 1'b0;
        end else if (req_valid) begin
            out_mask <= mask_c;
            if (req_lowpri) begin
                out_target     <= pick_c;
                out_target_idx <= pick_idx_c;
                out_target_hit <= pick_found_c;
            end else begin
                out_target     <= '0;
                out_target_idx <= '0;
                out_target_hit <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqdm_checker.sv
module irqdm_checker #(
    parameter int N_AGENTS = 8,
    localparam int IDXW = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_short,
    input logic [IDXW-1:0]     req_sender,
    input logic                req_lowpri,
    input logic                out_valid,
    input logic [N_AGENTS-1:0] out_mask,
    input logic [N_AGENTS-1:0] out_target,
    input logic [IDXW-1:0]     out_target_idx,
    input logic                out_target_hit
);

    localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

    a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    a_r7_self_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_short == 2'd1) |=> out_mask == (ONE << $past(req_sender)));

    a_r8_all_agents: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_short == 2'd2) |=> &out_mask);

    a_r9_all_but_self: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_short == 2'd3) |=>
            ($countones(out_mask) == N_AGENTS - 1) && !out_mask[$past(req_sender)]);

    a_r10_target_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_target));

    a_r10_target_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_target & ~out_mask) == '0));

    a_r10_idx_matches_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_target_hit) |-> out_target[out_target_idx]);

    a_r10_no_target_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lowpri) |=> (out_target == '0) && !out_target_hit);

endmodule

bind irqdm_top irqdm_checker #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_short      (req_short),
    .req_sender     (req_sender),
    .req_lowpri     (req_lowpri),
    .out_valid      (out_valid),
    .out_mask       (out_mask),
    .out_target     (out_target),
    .out_target_idx (out_target_idx),
    .out_target_hit (out_target_hit)
);

// File: tb/irqdm_top_test.sv
module irqdm_top_test;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_agent = '0;
    logic [1:0]    cfg_field = '0;
    logic [7:0]    cfg_data = '0;
    logic          req_valid = 1'b0;
    logic          req_logical = 1'b0;
    logic [1:0]    req_short = '0;
    logic [7:0]    req_dest = '0;
    logic [IW-1:0] req_sender = '0;
    logic          req_lowpri = 1'b0;
    logic          out_valid;
    logic [N-1:0]  out_mask;
    logic [N-1:0]  out_target;
    logic [IW-1:0] out_target_idx;
    logic          out_target_hit;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irqdm_top #(.N_AGENTS(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_agent(cfg_agent), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_logical(req_logical), .req_short(req_short),
        .req_dest(req_dest), .req_sender(req_sender), .req_lowpri(req_lowpri),
        .out_valid(out_valid), .out_mask(out_mask), .out_target(out_target),
        .out_target_idx(out_target_idx), .out_target_hit(out_target_hit)
    );

    typedef struct packed {
        logic          lg;
        logic [1:0]    sh;
        logic [7:0]    dst;
        logic [IW-1:0] snd;
        logic          lp;
        logic [N-1:0]  exp_mask;
        logic          exp_hit;
        logic [IW-1:0] exp_idx;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'hFF, 3'd0, 1'b0, 8'hFF, 1'b0, 3'd0},  // R2 broadcast
        '{1'b0, 2'd0, 8'h02, 3'd0, 1'b0, 8'h04, 1'b0, 3'd0},  // R3 single ID
        '{1'b0, 2'd0, 8'h21, 3'd0, 1'b0, 8'h60, 1'b0, 3'd0},  // R3 shared ID
        '{1'b0, 2'd0, 8'h05, 3'd0, 1'b0, 8'h00, 1'b0, 3'd0},  // R3 no ID
        '{1'b1, 2'd0, 8'h05, 3'd0, 1'b0, 8'h05, 1'b0, 3'd0},  // R4 flat
        '{1'b1, 2'd0, 8'h33, 3'd0, 1'b0, 8'h33, 1'b0, 3'd0},  // R5 cluster + flat
        '{1'b1, 2'd0, 8'h34, 3'd0, 1'b0, 8'h04, 1'b0, 3'd0},  // R5 cluster no low overlap
        '{1'b1, 2'd0, 8'h41, 3'd0, 1'b0, 8'h41, 1'b0, 3'd0},  // R5 other cluster
        '{1'b1, 2'd0, 8'hFF, 3'd0, 1'b0, 8'h0F, 1'b0, 3'd0},  // R6 odd model excluded
        '{1'b0, 2'd1, 8'hFF, 3'd6, 1'b0, 8'h40, 1'b0, 3'd0},  // R7 self
        '{1'b1, 2'd2, 8'h00, 3'd3, 1'b0, 8'hFF, 1'b0, 3'd0},  // R8 all
        '{1'b0, 2'd3, 8'hFF, 3'd0, 1'b0, 8'hFE, 1'b0, 3'd0},  // R9 others
        '{1'b0, 2'd3, 8'h00, 3'd7, 1'b0, 8'h7F, 1'b0, 3'd0},  // R9 others
        '{1'b0, 2'd0, 8'h21, 3'd0, 1'b1, 8'h60, 1'b1, 3'd5},  // R10 pick
        '{1'b1, 2'd0, 8'h33, 3'd0, 1'b1, 8'h33, 1'b1, 3'd0},  // R10 pick
        '{1'b0, 2'd0, 8'h05, 3'd0, 1'b1, 8'h00, 1'b0, 3'd0},  // R10 empty
        '{1'b0, 2'd3, 8'h00, 3'd0, 1'b1, 8'hFE, 1'b1, 3'd1}   // R10 pick
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [IW-1:0] a, input logic [1:0] f, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_agent = a; cfg_field = f; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives one request for one cycle; returns at the falling edge after the capture edge.
    task automatic send(input logic lg, input logic [1:0] sh, input logic [7:0] dst,
                        input logic [IW-1:0] snd, input logic lp);
        @(negedge clk);
        req_valid = 1'b1; req_logical = lg; req_short = sh;
        req_dest = dst; req_sender = snd; req_lowpri = lp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset outputs
        chk("R1 valid at reset", 32'(out_valid), 32'd0);
        chk("R1 mask at reset", 32'(out_mask), 32'd0);
        rst_n = 1'b1;

        // R1 reset configuration: logical bytes are zero, IDs equal index
        send(1'b1, 2'd0, 8'hFF, 3'd0, 1'b0);
        chk("R1 logical zero after reset", 32'(out_mask), 32'h00);
        send(1'b0, 2'd0, 8'h03, 3'd0, 1'b0);
        chk("R1 physical ID is index", 32'(out_mask), 32'h08);
        @(negedge clk);
        chk("R11 valid is one pulse", 32'(out_valid), 32'd0);

        // R12 configuration for the table
        cfg_write(3'd5, 2'd0, 8'h21);
        cfg_write(3'd6, 2'd0, 8'h21);
        for (int k = 0; k < 4; k++) cfg_write(IW'(k), 2'd1, 8'(1 << k));
        cfg_write(3'd4, 2'd1, 8'h31);
        cfg_write(3'd5, 2'd1, 8'h32);
        cfg_write(3'd6, 2'd1, 8'h41);
        cfg_write(3'd4, 2'd2, 8'hA0);   // R12 model takes low nibble: cluster
        cfg_write(3'd5, 2'd2, 8'h00);
        cfg_write(3'd6, 2'd2, 8'h00);
        cfg_write(3'd7, 2'd1, 8'hFF);
        cfg_write(3'd7, 2'd2, 8'h05);
        cfg_write(3'd2, 2'd3, 8'hFF);   // R12 code 3 writes nothing

        for (int v = 0; v < NV; v++) begin
            send(VECS[v].lg, VECS[v].sh, VECS[v].dst, VECS[v].snd, VECS[v].lp);
            chk($sformatf("R11 valid vec %0d", v), 32'(out_valid), 32'd1);
            chk($sformatf("R2-R10 mask vec %0d", v), 32'(out_mask), 32'(VECS[v].exp_mask));
            chk($sformatf("R10 hit vec %0d", v), 32'(out_target_hit), 32'(VECS[v].exp_hit));
            chk($sformatf("R10 idx vec %0d", v), 32'(out_target_idx), 32'(VECS[v].exp_idx));
            chk($sformatf("R10 target vec %0d", v), 32'(out_target),
                VECS[v].exp_hit ? 32'(1 << VECS[v].exp_idx) : 32'd0);
        end

        // R12 code 3 left agent 2 untouched: physical ID 2 and logical 0x04 still match
        send(1'b0, 2'd0, 8'h02, 3'd0, 1'b0);
        chk("R12 ignored field phys", 32'(out_mask), 32'h04);
        send(1'b1, 2'd0, 8'h04, 3'd0, 1'b0);
        chk("R12 ignored field logical", 32'(out_mask), 32'h04);

        // R12 physical ID rewrite
        cfg_write(3'd1, 2'd0, 8'h77);
        send(1'b0, 2'd0, 8'h77, 3'd0, 1'b0);
        chk("R12 physical ID write", 32'(out_mask), 32'h02);

        // R10 target clears when single-target delivery not requested
        send(1'b0, 2'd2, 8'h00, 3'd0, 1'b0);
        chk("R10 no target on normal", 32'(out_target_hit), 32'd0);

        // R11 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_logical = 1'b0; req_short = 2'd1; req_sender = 3'd2; req_lowpri = 1'b0;
        @(negedge clk);
        chk("R11 first of pair valid", 32'(out_valid), 32'd1);
        chk("R7 first of pair mask", 32'(out_mask), 32'h04);
        req_sender = 3'd4;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 second of pair valid", 32'(out_valid), 32'd1);
        chk("R7 second of pair mask", 32'(out_mask), 32'h10);
        @(negedge clk);
        chk("R11 drain", 32'(out_valid), 32'd0);
        chk("R11 mask held", 32'(out_mask), 32'h10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule